// File: doc/BRIEF.md
# Page-Table Entry Cache for Two-Level Address Translation

This block is a small, fully associative store of page-table entries. It sits beside a hardware page walker that resolves addresses in two stages: guest virtual to guest physical, then guest physical to system physical. Each probe from the walker names an entry by its system physical address, a dimension bit (guest table or nested table) and the table level the entry belongs to. A hit returns the stored 64-bit entry on the next cycle. A miss tells the walker to fetch the entry from the memory hierarchy. After that fetch the walker offers the entry back as a fill.

Admission is selective. Level 1 entries of either dimension are never stored, because final translations belong in the TLB and the lowest guest level is rarely reused. A configuration pin selects one of two modes. In guest-only mode the block ignores nested-table entries. In the other mode it caches both dimensions. The tree pseudo-LRU replacement always uses a free way first. A full flush empties the store in one cycle.

Neither port has back-pressure. A lookup is accepted in every cycle that `lkp_valid` is high, and exactly one response follows. A fill is accepted or silently dropped in the cycle it is presented. There is no ready signal and no stall, so the walker must never expect one.

Top module: `page_walk_cache`

## Requirements
- R1: After reset the store is empty, `rsp_valid` is low, and every lookup misses until a fill has been accepted.
- R2: Each cycle with `lkp_valid` high produces exactly one cycle with `rsp_valid` high, one clock later. `rsp_valid` is low in every other cycle, and a lookup is never refused or delayed.
- R3: An entry matches when its stored key {dimension bit, system physical address} equals the probe's key. On a hit `rsp_hit` is 1 and `rsp_entry` carries the stored 64-bit value. On a miss `rsp_hit` is 0 and `rsp_entry` is all zeros.
- R4: Level code 0 on `*_level` means table level 1, and codes 1 to 3 mean levels 2 to 4. A fill with level code 0 is dropped in either dimension and evicts nothing. A lookup with level code 0 always misses.
- R5: `mode_2d`=0 is guest-only mode. In that mode a fill with `fill_nested`=1 is dropped and a lookup with `lkp_nested`=1 misses. Nested entries already stored stay in place and hit again once `mode_2d` returns to 1.
- R6: The dimension bit is part of the key. A guest entry and a nested entry with the same system physical address are held as two separate entries.
- R7: A fill whose key is already stored overwrites that entry's data in place. It allocates no second copy and evicts nothing.
- R8: A new key goes into the lowest-numbered free way. When no way is free it replaces the way chosen by a 16-way binary-tree pseudo-LRU. Hits and fills both mark a way as most recently used. When a hit and a fill arrive in the same cycle, the fill is marked last.
- R9: `flush` invalidates every entry and resets the replacement state in one cycle. A lookup in the flush cycle misses, and a fill in the flush cycle is dropped.
- R10: A lookup sees the contents as they were before any fill in the same cycle. A lookup and a fill of the same key in one cycle therefore give a miss, and the entry hits from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_2d | input | 1 | 1: cache guest and nested entries; 0: guest entries only |
| flush | input | 1 | Invalidate all entries this cycle |
| lkp_valid | input | 1 | Lookup probe present |
| lkp_spa | input | ADDR_W | System physical address of the probed entry |
| lkp_nested | input | 1 | 1: nested-table entry, 0: guest-table entry |
| lkp_level | input | 2 | Table level of the probed entry (0 = level 1) |
| fill_valid | input | 1 | Fill offered this cycle |
| fill_spa | input | ADDR_W | System physical address of the filled entry |
| fill_nested | input | 1 | Dimension of the filled entry |
| fill_level | input | 2 | Table level of the filled entry (0 = level 1) |
| fill_entry | input | DATA_W | Entry value to store |
| rsp_valid | output | 1 | Lookup response present |
| rsp_hit | output | 1 | Response is a hit |
| rsp_entry | output | DATA_W | Stored entry on a hit, zero on a miss |

## Verification
The bound checker enforces several rules on every cycle: the one-cycle response pairing, the zeroed entry on a miss, and forced misses for level 1 probes, for nested probes in guest-only mode and for probes that meet a flush. Contents-dependent behaviour can only be shown by the bench's scenarios. This covers the data returned on a hit, in-place update, the separation by dimension bit, the dropped fills that evict nothing, and which way the pseudo-LRU gives up once the store is full. The bench's behavioural model tracks those contents cycle by cycle, including a long mixed run of lookups, fills, mode changes and flushes.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

  // Level encoding shared by lookup and fill ports: code 0 is table level 1.
  localparam logic [1:0] PWC_LEVEL_ONE = 2'd0;

  // Admission rule shared by the lookup gate and the fill filter.
  function automatic logic pwc_admit(input logic       nested,
                                     input logic [1:0] level,
                                     input logic       two_dim);
    return (level != PWC_LEVEL_ONE) && (!nested || two_dim);
  endfunction

endpackage

// File: rtl/pwc_tag_array.sv
module pwc_tag_array #(
  parameter int WAYS   = 16,
  parameter int TAG_W  = 41,
  parameter int DATA_W = 64,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic [TAG_W-1:0]      tag_a,
  input  logic [TAG_W-1:0]      tag_b,
  input  logic                  wr_en,
  input  logic [WAY_W-1:0]      wr_way,
  input  logic [TAG_W-1:0]      wr_tag,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [WAY_W-1:0]      rd_way,
  output logic [WAYS-1:0]       valid_o,
  output logic [WAYS-1:0]       match_a,
  output logic [WAYS-1:0]       match_b,
  output logic [DATA_W-1:0]     rd_data
);

  logic [TAG_W-1:0]  tag_q  [WAYS];
  logic [DATA_W-1:0] data_q [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic sel;
    assign sel = wr_en && (wr_way == WAY_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        valid_o[g] <= 1'b0;
      end else if (sel) begin
        valid_o[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tag_q[g]  <= '0;
        data_q[g] <= '0;
      end else if (sel) begin
        tag_q[g]  <= wr_tag;
        data_q[g] <= wr_data;
      end
    end

    assign match_a[g] = valid_o[g] && (tag_q[g] == tag_a);
    assign match_b[g] = valid_o[g] && (tag_q[g] == tag_b);
  end

  assign rd_data = data_q[rd_way];

endmodule

// File: rtl/pwc_plru.sv
module pwc_plru #(
  parameter int WAYS = 16,
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             hit_en,
  input  logic [WAY_W-1:0] hit_way,
  input  logic             fill_en,
  input  logic [WAY_W-1:0] fill_way,
  output logic [WAY_W-1:0] victim
);

  logic [NODES-1:0] tree_q, tree_mid, tree_d;

  // Walk root to leaf along the way's bits; each node is set to steer away.
  function automatic logic [NODES-1:0] steer_away(input logic [NODES-1:0] t,
                                                  input logic [WAY_W-1:0] w);
    logic [NODES-1:0] r;
    logic [WAY_W-1:0] node;
    logic             b;
    r    = t;
    node = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b       = w[WAY_W-1-l];
      r[node] = ~b;
      node    = WAY_W'({node, 1'b1} + {{WAY_W{1'b0}}, b});
    end
    return r;
  endfunction

  function automatic logic [WAY_W-1:0] follow(input logic [NODES-1:0] t);
    logic [WAY_W-1:0] node;
    logic [WAY_W-1:0] v;
    logic             b;
    node = '0;
    v    = '0;
    for (int l = 0; l < WAY_W; l++) begin
      b              = t[node];
      v[WAY_W-1-l]   = b;
      node           = WAY_W'({node, 1'b1} + {{WAY_W{1'b0}}, b});
    end
    return v;
  endfunction

  always_comb begin
    tree_mid = hit_en  ? steer_away(tree_q, hit_way)    : tree_q;
    tree_d   = fill_en ? steer_away(tree_mid, fill_way) : tree_mid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) tree_q <= '0;
    else                 tree_q <= tree_d;
  end

  assign victim = follow(tree_q);

endmodule

// File: rtl/page_walk_cache.sv
module page_walk_cache #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64,
  parameter int WAYS   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_2d,
  input  logic              flush,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_spa,
  input  logic              lkp_nested,
  input  logic [1:0]        lkp_level,
  input  logic              fill_valid,
  input  logic [ADDR_W-1:0] fill_spa,
  input  logic              fill_nested,
  input  logic [1:0]        fill_level,
  input  logic [DATA_W-1:0] fill_entry,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_entry
);
  import pwc_pkg::*;

  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W + 1;

  logic [TAG_W-1:0]  lkp_tag, fill_tag;
  logic [WAYS-1:0]   valid_vec, lkp_match, fill_match;
  logic [DATA_W-1:0] rd_data;
  logic [WAY_W-1:0]  lkp_way, fill_way, plru_victim, free_way;
  logic              lkp_ok, lkp_hit, fill_ok, fill_present, any_free;

  // Lowest set index of a way vector.
  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (v[i]) r = WAY_W'(i);
    end
    return r;
  endfunction

  assign lkp_tag  = {lkp_nested, lkp_spa};
  assign fill_tag = {fill_nested, fill_spa};

  always_comb begin
    lkp_ok       = lkp_valid && !flush && pwc_admit(lkp_nested, lkp_level, mode_2d);
    lkp_hit      = lkp_ok && (|lkp_match);
    lkp_way      = lowest(lkp_match);
    fill_ok      = fill_valid && !flush && pwc_admit(fill_nested, fill_level, mode_2d);
    fill_present = |fill_match;
    any_free     = ~&valid_vec;
    free_way     = lowest(~valid_vec);
    if (fill_present)  fill_way = lowest(fill_match);
    else if (any_free) fill_way = free_way;
    else               fill_way = plru_victim;
  end

  pwc_tag_array #(
    .WAYS   (WAYS),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (flush),
    .tag_a   (lkp_tag),
    .tag_b   (fill_tag),
    .wr_en   (fill_ok),
    .wr_way  (fill_way),
    .wr_tag  (fill_tag),
    .wr_data (fill_entry),
    .rd_way  (lkp_way),
    .valid_o (valid_vec),
    .match_a (lkp_match),
    .match_b (fill_match),
    .rd_data (rd_data)
  );

  pwc_plru #(
    .WAYS (WAYS)
  ) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (flush),
    .hit_en   (lkp_hit),
    .hit_way  (lkp_way),
    .fill_en  (fill_ok),
    .fill_way (fill_way),
    .victim   (plru_victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_entry <= '0;
    end else begin
      rsp_valid <= lkp_valid;
      rsp_hit   <= lkp_hit;
      rsp_entry <= lkp_hit ? rd_data : '0;
    end
  end

endmodule

// File: rtl/pwc_checker.sv
module pwc_checker #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_2d,
  input logic              flush,
  input logic              lkp_valid,
  input logic [ADDR_W-1:0] lkp_spa,
  input logic              lkp_nested,
  input logic [1:0]        lkp_level,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_spa,
  input logic              fill_nested,
  input logic [1:0]        fill_level,
  input logic [DATA_W-1:0] fill_entry,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic [DATA_W-1:0] rsp_entry
);

  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> rsp_valid);

  p_no_spurious_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !rsp_valid);

  p_miss_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_entry == '0));

  p_hit_needs_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);

  p_level_one_miss_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_level == 2'd0) |=> (rsp_valid && !rsp_hit));

  p_guest_only_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && lkp_nested && !mode_2d) |=> !rsp_hit);

  p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && flush) |=> (rsp_valid && !rsp_hit));

endmodule

bind page_walk_cache pwc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_pwc_checker (.*);

// File: tb/page_walk_cache_bench.sv
module page_walk_cache_bench;

  localparam int AW = 40;
  localparam int DW = 64;
  localparam int NW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_2d = 1'b1;
  logic          flush = 1'b0;
  logic          lkp_valid = 1'b0;
  logic [AW-1:0] lkp_spa = '0;
  logic          lkp_nested = 1'b0;
  logic [1:0]    lkp_level = 2'd1;
  logic          fill_valid = 1'b0;
  logic [AW-1:0] fill_spa = '0;
  logic          fill_nested = 1'b0;
  logic [1:0]    fill_level = 2'd1;
  logic [DW-1:0] fill_entry = '0;
  logic          rsp_valid, rsp_hit;
  logic [DW-1:0] rsp_entry;

  page_walk_cache #(.ADDR_W(AW), .DATA_W(DW), .WAYS(NW)) u_page_walk_cache (.*);

  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  string cur_req = "R1";

  // Behavioural reference model.
  bit          m_valid [NW];
  bit [AW:0]   m_key   [NW];
  bit [DW-1:0] m_data  [NW];
  bit          m_tree  [NW-1];
  bit          e_valid, e_hit;
  bit [DW-1:0] e_entry;

  function automatic bit admit(bit nested, bit [1:0] lvl, bit two);
    return (lvl != 2'd0) && (!nested || two);
  endfunction

  function automatic void mark_used(int w);
    int node = 0;
    for (int l = 3; l >= 0; l--) begin
      int b = (w >> l) & 1;
      m_tree[node] = (b == 0);
      node = 2 * node + 1 + b;
    end
  endfunction

  function automatic int pick_old();
    int node = 0;
    int v = 0;
    for (int l = 0; l < 4; l++) begin
      int b = m_tree[node];
      v = v * 2 + b;
      node = 2 * node + 1 + b;
    end
    return v;
  endfunction

  function automatic int find(bit [AW:0] k);
    for (int i = 0; i < NW; i++) if (m_valid[i] && m_key[i] == k) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_valid[i]) m_valid[i] = 0;
      foreach (m_tree[i]) m_tree[i] = 0;
      e_valid = 0; e_hit = 0; e_entry = '0;
    end else begin
      int hw, fw;
      e_valid = lkp_valid; e_hit = 0; e_entry = '0;
      if (flush) begin
        foreach (m_valid[i]) m_valid[i] = 0;
        foreach (m_tree[i]) m_tree[i] = 0;
      end else begin
        hw = -1; fw = -1;
        if (lkp_valid && admit(lkp_nested, lkp_level, mode_2d))
          hw = find({lkp_nested, lkp_spa});
        if (fill_valid && admit(fill_nested, fill_level, mode_2d)) begin
          fw = find({fill_nested, fill_spa});
          if (fw < 0) for (int i = NW - 1; i >= 0; i--) if (!m_valid[i]) fw = i;
          if (fw < 0) fw = pick_old();
        end
        if (hw >= 0) begin
          e_hit = 1; e_entry = m_data[hw]; mark_used(hw);
        end
        if (fw >= 0) begin
          m_valid[fw] = 1; m_key[fw] = {fill_nested, fill_spa};
          m_data[fw] = fill_entry; mark_used(fw);
        end
      end
    end
  end

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rsp_valid !== e_valid || rsp_hit !== e_hit || rsp_entry !== e_entry) begin
      failures++;
      $display("FAIL %s model: got v=%0b h=%0b d=%h exp v=%0b h=%0b d=%h",
               cur_req, rsp_valid, rsp_hit, rsp_entry, e_valid, e_hit, e_entry);
    end
  endtask

  task automatic expect_rsp(string req, bit hit, bit [DW-1:0] d);
    checks++;
    if (rsp_valid !== 1'b1 || rsp_hit !== hit || rsp_entry !== d) begin
      failures++;
      $display("FAIL %s directed: got v=%0b h=%0b d=%h exp v=1 h=%0b d=%h",
               req, rsp_valid, rsp_hit, rsp_entry, hit, d);
    end
  endtask

  task automatic clear_in();
    flush = 0; lkp_valid = 0; fill_valid = 0;
  endtask

  task automatic lookup(bit [AW-1:0] a, bit n, bit [1:0] lv);
    clear_in();
    lkp_valid = 1; lkp_spa = a; lkp_nested = n; lkp_level = lv;
    step();
    clear_in();
  endtask

  task automatic fill(bit [AW-1:0] a, bit n, bit [1:0] lv, bit [DW-1:0] d);
    clear_in();
    fill_valid = 1; fill_spa = a; fill_nested = n; fill_level = lv; fill_entry = d;
    step();
    clear_in();
  endtask

  function automatic bit [AW-1:0] kaddr(int i);
    return AW'(40'h80_0000_0000 + i * 8);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      failures++;
      $display("FAIL watchdog: got cycles=%0d exp below 60000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state and empty store
    cur_req = "R1";
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R1 reset: got rsp_valid=%0b exp 0", rsp_valid);
    end
    lookup(kaddr(1), 0, 2'd2);
    expect_rsp("R1", 0, '0);

    // R2/R3: fill then hit, back-to-back lookups
    cur_req = "R3";
    fill(kaddr(1), 0, 2'd2, 64'hA1A1_0000_1111_0001);
    lookup(kaddr(1), 0, 2'd2);
    expect_rsp("R3", 1, 64'hA1A1_0000_1111_0001);
    cur_req = "R2";
    lkp_valid = 1; lkp_spa = kaddr(1); lkp_nested = 0; lkp_level = 2'd3;
    step();
    expect_rsp("R2", 1, 64'hA1A1_0000_1111_0001);
    step();
    expect_rsp("R2", 1, 64'hA1A1_0000_1111_0001);
    clear_in();
    step();
    checks++;
    if (rsp_valid !== 1'b0) begin
      failures++;
      $display("FAIL R2 idle: got rsp_valid=%0b exp 0", rsp_valid);
    end

    // R6: same address, other dimension
    cur_req = "R6";
    lookup(kaddr(1), 1, 2'd2);
    expect_rsp("R6", 0, '0);
    fill(kaddr(1), 1, 2'd2, 64'hBEEF_0000_0000_0002);
    lookup(kaddr(1), 1, 2'd2);
    expect_rsp("R6", 1, 64'hBEEF_0000_0000_0002);
    lookup(kaddr(1), 0, 2'd2);
    expect_rsp("R6", 1, 64'hA1A1_0000_1111_0001);

    // R4: level 1 never stored, in either dimension
    cur_req = "R4";
    fill(kaddr(2), 0, 2'd0, 64'h1);
    fill(kaddr(3), 1, 2'd0, 64'h2);
    lookup(kaddr(2), 0, 2'd1);
    expect_rsp("R4", 0, '0);
    lookup(kaddr(3), 1, 2'd1);
    expect_rsp("R4", 0, '0);
    lookup(kaddr(1), 0, 2'd0);
    expect_rsp("R4", 0, '0);

    // R5: guest-only mode
    cur_req = "R5";
    mode_2d = 0;
    fill(kaddr(4), 1, 2'd2, 64'h44);
    lookup(kaddr(1), 1, 2'd2);
    expect_rsp("R5", 0, '0);
    lookup(kaddr(1), 0, 2'd2);
    expect_rsp("R5", 1, 64'hA1A1_0000_1111_0001);
    mode_2d = 1;
    lookup(kaddr(4), 1, 2'd2);
    expect_rsp("R5", 0, '0);
    lookup(kaddr(1), 1, 2'd2);
    expect_rsp("R5", 1, 64'hBEEF_0000_0000_0002);

    // R7: in-place update
    cur_req = "R7";
    fill(kaddr(1), 0, 2'd3, 64'hCAFE_0000_0000_0007);
    lookup(kaddr(1), 0, 2'd3);
    expect_rsp("R7", 1, 64'hCAFE_0000_0000_0007);

    // R10: lookup and fill of one key in the same cycle
    cur_req = "R10";
    clear_in();
    lkp_valid = 1; lkp_spa = kaddr(9); lkp_nested = 0; lkp_level = 2'd2;
    fill_valid = 1; fill_spa = kaddr(9); fill_nested = 0; fill_level = 2'd2;
    fill_entry = 64'h9999;
    step();
    expect_rsp("R10", 0, '0);
    clear_in();
    lookup(kaddr(9), 0, 2'd2);
    expect_rsp("R10", 1, 64'h9999);

    // R8: fill order and pseudo-LRU eviction
    cur_req = "R8";
    clear_in(); flush = 1; step(); clear_in();
    for (int i = 0; i < 16; i++) fill(kaddr(100 + i), 0, 2'd2, 64'(1000 + i));
    fill(kaddr(200), 0, 2'd2, 64'd2000);
    lookup(kaddr(100), 0, 2'd2);
    expect_rsp("R8", 0, '0);
    lookup(kaddr(101), 0, 2'd2);
    expect_rsp("R8", 1, 64'd1001);
    lookup(kaddr(200), 0, 2'd2);
    expect_rsp("R8", 1, 64'd2000);
    fill(kaddr(201), 0, 2'd3, 64'd2001);
    fill(kaddr(2), 0, 2'd0, 64'd5);
    for (int i = 1; i < 16; i++) lookup(kaddr(100 + i), 0, 2'd2);

    // R9: flush with a lookup and a fill in the same cycle
    cur_req = "R9";
    clear_in();
    flush = 1;
    lkp_valid = 1; lkp_spa = kaddr(101); lkp_nested = 0; lkp_level = 2'd2;
    fill_valid = 1; fill_spa = kaddr(300); fill_nested = 0; fill_level = 2'd2;
    fill_entry = 64'h3;
    step();
    expect_rsp("R9", 0, '0);
    clear_in();
    lookup(kaddr(101), 0, 2'd2);
    expect_rsp("R9", 0, '0);
    lookup(kaddr(300), 0, 2'd2);
    expect_rsp("R9", 0, '0);

    // Mixed traffic compared against the model every cycle (R2..R10)
    cur_req = "R8";
    for (int c = 0; c < 3000; c++) begin
      clear_in();
      lkp_valid   = ($urandom % 4) != 0;
      lkp_spa     = kaddr($urandom % 24);
      lkp_nested  = $urandom % 2;
      lkp_level   = $urandom % 4;
      fill_valid  = ($urandom % 3) == 0;
      fill_spa    = kaddr($urandom % 24);
      fill_nested = $urandom % 2;
      fill_level  = $urandom % 4;
      fill_entry  = {$urandom, $urandom};
      flush       = ($urandom % 97) == 0;
      if (($urandom % 53) == 0) mode_2d = ~mode_2d;
      step();
    end
    clear_in();
    step();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule